// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer between an 8-bit CPU core and its interrupt controller. When the core reports the end of an instruction and an interrupt is active while global interrupts are enabled, the sequencer takes over for a fixed 13-cycle acknowledge sequence. During that sequence it saves the 16-bit program counter and the flag byte to a byte-wide stack memory. It then clears the flags, which also disables further interrupts. Last, it acknowledges the controller and loads the program counter with a zero high byte and the controller's vector as the low byte.

When the core reports that a return-from-interrupt has completed decode, the sequencer runs a fixed 10-cycle return sequence. This sequence pops the flag byte and both program-counter bytes and reloads the core registers. Because the saved flags come back, the interrupt enable returns to the value it had before entry. If an interrupt is still active and the restored flags enable it, a new entry starts straight after the return, with no normal instruction in between. While a sequence runs, the block holds `seq_busy` high so that the core stalls.

Top module: `isr_sequencer`

## Requirements
- R1: An entry starts only in a cycle where `insn_done` and `irq_active` are both 1 and flag bit 0 (the global interrupt enable) is 1. `seq_busy` rises in the following cycle. While `insn_done` is 0, an active interrupt does not start an entry.
- R2: While flag bit 0 is 0, no entry starts, even when `insn_done` and `irq_active` are both 1.
- R3: An entry keeps `seq_busy` high for exactly 13 consecutive cycles, counted as entry cycles 0 to 12.
- R4: Entry cycles 0, 1 and 2 each write one byte with `stk_we`: first PC[15:8], then PC[7:0], then the flags. The writes go to addresses sp, sp+1 and sp+2, and `sp_out` increases by one after each write. PC and flags are the values present at the cycle the entry started.
- R5: In entry cycle 3, `flags_load` is 1 with `flags_next` equal to 0.
- R6: In entry cycle 4, `irq_ack` pulses for one cycle, and `pc_load` is 1 with `pc_next` equal to {8'h00, `irq_vector`}.
- R7: A return starts when `insn_done` and `reti_go` are both 1 while the block is idle. It keeps `seq_busy` high for exactly 10 cycles. Return cycles 0, 1 and 2 read with `stk_re` from addresses sp-1, sp-2 and sp-3, and `sp_out` decreases by one with each read. The stack memory returns the read data one cycle after each read. In return cycle 4, `pc_load` and `flags_load` restore the popped PC and flags.
- R8: In the last return cycle, if `irq_active` is 1 and the restored flag bit 0 is 1, a new entry begins in the very next cycle without waiting for `insn_done`.
- R9: `insn_done` and `reti_go` have no effect while `seq_busy` is 1. A stack read and a stack write never happen in the same cycle.
- R10: While `rst_n` is 0 at a clock edge, including in the middle of a sequence, the block returns to idle: `seq_busy`, `stk_we`, `stk_re`, `irq_ack`, `pc_load` and `flags_load` are 0, and `sp_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | Core strobe: the current instruction has finished |
| reti_go | input | 1 | Core strobe: the finishing instruction is a return-from-interrupt |
| irq_active | input | 1 | Interrupt controller reports an enabled, pending interrupt |
| irq_vector | input | 8 | Vector low byte from the interrupt controller |
| pc_in | input | 16 | Core program counter (address of the next instruction) |
| flags_in | input | 8 | Core flag register; bit 0 is the global interrupt enable |
| stk_rdata | input | 8 | Stack memory read data, valid one cycle after `stk_re` |
| stk_we | output | 1 | Stack memory write strobe |
| stk_re | output | 1 | Stack memory read strobe |
| stk_addr | output | 8 | Stack memory address |
| stk_wdata | output | 8 | Stack memory write data |
| sp_out | output | 8 | Current stack pointer |
| pc_load | output | 1 | Load `pc_next` into the core program counter |
| pc_next | output | 16 | Program counter value to load |
| flags_load | output | 1 | Load `flags_next` into the core flag register |
| flags_next | output | 8 | Flag value to load |
| irq_ack | output | 1 | Acknowledge pulse; the vector is taken in this cycle |
| seq_busy | output | 1 | A sequence is running; the core must stall |

## Verification
The assertions check the following on every cycle:
- an entry begins only after an instruction boundary with an active interrupt, and never while the enable flag is clear;
- an entry lasts 13 cycles;
- the stack pointer moves by exactly one on each push or pop;
- the flag clear comes right before the acknowledge;
- a chained entry follows a return whenever its condition holds.

Only the bench scenarios can show the rest: the byte order and addresses on the stack, the exact vector that reaches the program counter, the restored values after a round trip, and the chained entry pushing the restored state. They also show that strobes arriving mid-sequence are ignored and that a reset in the middle of a sequence returns the block to idle.

// File: rtl/isr_seq_pkg.sv
// Shared types for the interrupt entry/return sequencer.
// Assumes: one sequence runs at a time; idle is the reset state.
package isr_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ENTER = 2'd1,
        SEQ_LEAVE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/isr_seq_fsm.sv
// Sequencer state machine: decides when an entry or a return starts
// and counts the cycle step inside each fixed-length sequence.
// Assumes: insn_done is a one-cycle strobe from the core, and flags_in
// already reflects any flag load issued earlier in a return.
module isr_seq_fsm
    import isr_seq_pkg::*;
#(
    parameter int ENTRY_CYCLES = 13,
    parameter int RET_CYCLES   = 10,
    parameter int FLAG_W       = 8,
    parameter int GIE_BIT      = 0,
    parameter int CW           = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              reti_go,
    input  logic              irq_active,
    input  logic [FLAG_W-1:0] flags_in,
    output seq_state_t        state,
    output logic [CW-1:0]     step,
    output logic              take_irq
);

    localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYCLES - 1);
    localparam logic [CW-1:0] RET_LAST   = CW'(RET_CYCLES - 1);

    seq_state_t nxt;
    logic       gie;

    assign gie = flags_in[GIE_BIT];

    // Next-state choice; return has priority over a new entry at a boundary.
    always_comb begin
        nxt      = state;
        take_irq = 1'b0;
        case (state)
            SEQ_IDLE: begin
                if (insn_done && reti_go) begin
                    nxt = SEQ_LEAVE;
                end else if (insn_done && irq_active && gie) begin
                    nxt      = SEQ_ENTER;
                    take_irq = 1'b1;
                end
            end
            SEQ_ENTER: begin
                if (step == ENTRY_LAST) nxt = SEQ_IDLE;
            end
            SEQ_LEAVE: begin
                if (step == RET_LAST) begin
                    if (irq_active && gie) begin
                        nxt      = SEQ_ENTER;
                        take_irq = 1'b1;
                    end else begin
                        nxt = SEQ_IDLE;
                    end
                end
            end
            default: nxt = SEQ_IDLE;
        endcase
    end

    // State and step registers; step restarts whenever the state changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            step  <= '0;
        end else begin
            state <= nxt;
            step  <= (nxt != state) ? '0 : step + 1'b1;
        end
    end

    // Independent run-length counter of consecutive entry cycles.
    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_q <= '0;
        else if (state == SEQ_ENTER) run_q <= run_q + 1'b1;
        else                         run_q <= '0;
    end

    // R1: an entry that follows idle came from a boundary with an active interrupt.
    p_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ENTER && $past(state) == SEQ_IDLE) |-> $past(insn_done && irq_active));

    // R2: a cleared enable flag in idle blocks any entry.
    p_gie_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && !gie) |=> state != SEQ_ENTER);

    // R3: the entry run is exactly ENTRY_CYCLES long.
    p_entry_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ENTER && nxt != SEQ_ENTER) |-> run_q == (CW+1)'(ENTRY_CYCLES - 1));

    // R8: an enabled, active interrupt at the end of a return chains an entry.
    p_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_LEAVE && step == RET_LAST && irq_active && gie) |=> state == SEQ_ENTER);

endmodule

// File: rtl/isr_seq_sp.sv
// Stack pointer: post-increment on push, pre-decrement on pop.
// Assumes: push and pop are never requested together.
module isr_seq_sp #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] addr
);

    // Pop addresses the byte below the pointer; push addresses the pointer.
    assign addr = pop ? (sp - SP_W'(1)) : sp;

    // Pointer update after each stack access.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (push) sp <= sp + SP_W'(1);
        else if (pop)  sp <= sp - SP_W'(1);
    end

    // R4: every push moves the pointer up by one.
    p_sp_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp == $past(sp) + SP_W'(1));

    // R7: every pop moves the pointer down by one.
    p_sp_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> sp == $past(sp) - SP_W'(1));

    // R9: reads and writes are mutually exclusive.
    p_push_pop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/isr_seq_hold.sv
// Holding registers for the PC and flags: captured from the core at the
// start of an entry, refilled byte by byte from stack read data on return.
// Assumes: the load strobes are only raised when read data is valid.
module isr_seq_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [2*DW-1:0] pc_in,
    input  logic [DW-1:0] flags_in,
    input  logic          ld_f,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [DW-1:0] rdata,
    output logic [2*DW-1:0] hold_pc,
    output logic [DW-1:0] hold_f
);

    // Capture core state or assemble popped bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_pc <= '0;
            hold_f  <= '0;
        end else if (capture) begin
            hold_pc <= pc_in;
            hold_f  <= flags_in;
        end else begin
            if (ld_f)  hold_f              <= rdata;
            if (ld_lo) hold_pc[DW-1:0]     <= rdata;
            if (ld_hi) hold_pc[2*DW-1:DW]  <= rdata;
        end
    end

    // R4: saved state stays put while nothing loads it.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !ld_f && !ld_lo && !ld_hi) |=> ($stable(hold_pc) && $stable(hold_f)));

endmodule

// File: rtl/isr_sequencer.sv
// Interrupt entry/return sequencer top. Decodes the state/step of the
// sequencer into stack, PC and flag controls for the core.
// Assumes: byte-wide stack memory with one-cycle read latency; the core
// stalls while seq_busy is high and applies pc_load/flags_load at the edge.
module isr_sequencer
    import isr_seq_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SP_W         = 8,
    parameter int ENTRY_CYCLES = 13,
    parameter int RET_CYCLES   = 10,
    parameter int GIE_BIT      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              reti_go,
    input  logic              irq_active,
    input  logic [DW-1:0]     irq_vector,
    input  logic [2*DW-1:0]   pc_in,
    input  logic [DW-1:0]     flags_in,
    input  logic [DW-1:0]     stk_rdata,
    output logic              stk_we,
    output logic              stk_re,
    output logic [SP_W-1:0]   stk_addr,
    output logic [DW-1:0]     stk_wdata,
    output logic [SP_W-1:0]   sp_out,
    output logic              pc_load,
    output logic [2*DW-1:0]   pc_next,
    output logic              flags_load,
    output logic [DW-1:0]     flags_next,
    output logic              irq_ack,
    output logic              seq_busy
);

    localparam int MAXC = (ENTRY_CYCLES > RET_CYCLES) ? ENTRY_CYCLES : RET_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    // Entry steps
    localparam logic [CW-1:0] ST_PUSH_HI = CW'(0);
    localparam logic [CW-1:0] ST_PUSH_LO = CW'(1);
    localparam logic [CW-1:0] ST_PUSH_F  = CW'(2);
    localparam logic [CW-1:0] ST_CLEAR   = CW'(3);
    localparam logic [CW-1:0] ST_VECTOR  = CW'(4);
    // Return steps
    localparam logic [CW-1:0] RT_RD_LAST = CW'(2);
    localparam logic [CW-1:0] RT_GET_F   = CW'(1);
    localparam logic [CW-1:0] RT_GET_LO  = CW'(2);
    localparam logic [CW-1:0] RT_GET_HI  = CW'(3);
    localparam logic [CW-1:0] RT_RESTORE = CW'(4);

    seq_state_t      state;
    logic [CW-1:0]   step;
    logic            take_irq;
    logic            in_enter;
    logic            in_leave;
    logic [2*DW-1:0] hold_pc;
    logic [DW-1:0]   hold_f;

    isr_seq_fsm #(
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .RET_CYCLES   (RET_CYCLES),
        .FLAG_W       (DW),
        .GIE_BIT      (GIE_BIT),
        .CW           (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_done  (insn_done),
        .reti_go    (reti_go),
        .irq_active (irq_active),
        .flags_in   (flags_in),
        .state      (state),
        .step       (step),
        .take_irq   (take_irq)
    );

    assign in_enter = (state == SEQ_ENTER);
    assign in_leave = (state == SEQ_LEAVE);

    // Stack strobes: three pushes at the start of entry, three pops at the start of return.
    assign stk_we = in_enter && (step <= ST_PUSH_F);
    assign stk_re = in_leave && (step <= RT_RD_LAST);

    isr_seq_sp #(
        .SP_W (SP_W)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_we),
        .pop   (stk_re),
        .sp    (sp_out),
        .addr  (stk_addr)
    );

    isr_seq_hold #(
        .DW (DW)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (take_irq),
        .pc_in    (pc_in),
        .flags_in (flags_in),
        .ld_f     (in_leave && step == RT_GET_F),
        .ld_lo    (in_leave && step == RT_GET_LO),
        .ld_hi    (in_leave && step == RT_GET_HI),
        .rdata    (stk_rdata),
        .hold_pc  (hold_pc),
        .hold_f   (hold_f)
    );

    // Write data selection in push order: PC high, PC low, flags.
    always_comb begin
        case (step)
            ST_PUSH_HI: stk_wdata = hold_pc[2*DW-1:DW];
            ST_PUSH_LO: stk_wdata = hold_pc[DW-1:0];
            default:    stk_wdata = hold_f;
        endcase
    end

    // Core register loads: clear/vector on entry, restore on return.
    assign irq_ack    = in_enter && (step == ST_VECTOR);
    assign flags_load = (in_enter && step == ST_CLEAR) || (in_leave && step == RT_RESTORE);
    assign flags_next = in_leave ? hold_f : '0;
    assign pc_load    = irq_ack || (in_leave && step == RT_RESTORE);
    assign pc_next    = in_leave ? hold_pc : {{DW{1'b0}}, irq_vector};
    assign seq_busy   = (state != SEQ_IDLE);

    // R5: the acknowledge is preceded by a flag clear in the cycle before.
    p_clear_before_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ($past(flags_load) && $past(flags_next) == '0));

    // R6: the acknowledge is a single-cycle pulse.
    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R7: a restore loads PC and flags together.
    p_restore_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !irq_ack) |-> flags_load);

    // R9: no stack activity while idle.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> !(stk_we || stk_re));

endmodule

// File: tb/isr_sequencer_bench.sv
module isr_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0;
    logic        reti_go = 1'b0;
    logic        irq_active = 1'b0;
    logic [7:0]  irq_vector = 8'h00;
    logic [15:0] core_pc;
    logic [7:0]  core_f;
    logic [7:0]  stk_rdata;
    logic        stk_we, stk_re, pc_load, flags_load, irq_ack, seq_busy;
    logic [7:0]  stk_addr, stk_wdata, sp_out, flags_next;
    logic [15:0] pc_next;

    logic        tb_set = 1'b0;
    logic [15:0] tb_pc = 16'h0;
    logic [7:0]  tb_f = 8'h0;
    logic [7:0]  mem [256];

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    isr_sequencer u_isr_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_done  (insn_done),
        .reti_go    (reti_go),
        .irq_active (irq_active),
        .irq_vector (irq_vector),
        .pc_in      (core_pc),
        .flags_in   (core_f),
        .stk_rdata  (stk_rdata),
        .stk_we     (stk_we),
        .stk_re     (stk_re),
        .stk_addr   (stk_addr),
        .stk_wdata  (stk_wdata),
        .sp_out     (sp_out),
        .pc_load    (pc_load),
        .pc_next    (pc_next),
        .flags_load (flags_load),
        .flags_next (flags_next),
        .irq_ack    (irq_ack),
        .seq_busy   (seq_busy)
    );

    // Core register model plus stack memory with one-cycle read latency.
    always @(posedge clk) begin
        if (tb_set) begin
            core_pc <= tb_pc;
            core_f  <= tb_f;
        end else begin
            if (pc_load)    core_pc <= pc_next;
            if (flags_load) core_f  <= flags_next;
        end
        if (stk_we) mem[stk_addr] <= stk_wdata;
        if (stk_re) stk_rdata <= mem[stk_addr];
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [45:0] pk(input logic b, we, re, fl, ack, pl,
                                       input logic [7:0] ad, wd, fn, input logic [15:0] pn);
        return {b, we, re, fl, ack, pl, (we | re) ? ad : 8'h00, we ? wd : 8'h00,
                fl ? fn : 8'h00, pl ? pn : 16'h0000};
    endfunction

    function automatic logic [45:0] act_pk();
        return pk(seq_busy, stk_we, stk_re, flags_load, irq_ack, pc_load,
                  stk_addr, stk_wdata, flags_next, pc_next);
    endfunction

    task automatic set_core(input logic [15:0] pc, input logic [7:0] f);
        @(negedge clk);
        tb_set = 1'b1; tb_pc = pc; tb_f = f;
        @(negedge clk);
        tb_set = 1'b0;
    endtask

    // Checks entry cycles 0..12; the next negedge must be entry cycle 0.
    task automatic entry_body(input logic [15:0] pc, input logic [7:0] f, input logic [7:0] vec,
                              input logic [7:0] sp0, input bit noise);
        for (int k = 0; k < 13; k++) begin
            @(negedge clk);
            insn_done = noise;
            reti_go   = noise && (k == 6);
            if (k == 5) irq_active = 1'b0;
            #1;
            // R3 R4 R5 R6 R9: per-cycle entry outputs
            chk("R3/R4/R5/R6 entry cycle", act_pk(),
                pk(1'b1, k < 3, 1'b0, k == 3, k == 4, k == 4, sp0 + 8'(k),
                   (k == 0) ? pc[15:8] : (k == 1) ? pc[7:0] : f, 8'h00, {8'h00, vec}));
        end
        @(negedge clk);
        insn_done = 1'b0; reti_go = 1'b0;
        #1;
        chk("R3 busy low after 13", {63'b0, seq_busy}, 64'd0);
        chk("R6 core pc at vector", {48'b0, core_pc}, {48'b0, 8'h00, vec});
        chk("R5 core flags cleared", {56'b0, core_f}, 64'd0);
        chk("R4 sp after pushes", {56'b0, sp_out}, {56'b0, sp0 + 8'd3});
        chk("R4 stacked bytes", {40'b0, mem[sp0], mem[sp0 + 8'd1], mem[sp0 + 8'd2]},
            {40'b0, pc[15:8], pc[7:0], f});
    endtask

    task automatic start_entry(input logic [7:0] vec);
        @(negedge clk);
        insn_done = 1'b1; irq_active = 1'b1; irq_vector = vec;
    endtask

    // Return from sp1; checks return cycles 0..9.
    task automatic do_return(input logic [15:0] pc, input logic [7:0] f,
                             input logic [7:0] sp1, input bit chain);
        @(negedge clk);
        insn_done = 1'b1; reti_go = 1'b1;
        for (int r = 0; r < 10; r++) begin
            @(negedge clk);
            insn_done = 1'b0; reti_go = 1'b0;
            #1;
            // R7: per-cycle return outputs
            chk("R7 return cycle", act_pk(),
                pk(1'b1, 1'b0, r < 3, r == 4, 1'b0, r == 4, sp1 - 8'(1 + r), 8'h00, f, pc));
        end
        if (!chain) begin
            @(negedge clk);
            #1;
            chk("R7 busy low after 10", {63'b0, seq_busy}, 64'd0);
            chk("R7 restored pc/flags", {40'b0, core_pc, core_f}, {40'b0, pc, f});
            chk("R7 sp after pops", {56'b0, sp_out}, {56'b0, sp1 - 8'd3});
        end
    endtask

    localparam logic [31:0] VECS [5] = '{
        {16'h1234, 8'h01, 8'h04},
        {16'hABCD, 8'hFF, 8'h10},
        {16'h00FF, 8'h81, 8'h20},
        {16'hFF00, 8'h55, 8'h08},
        {16'h8001, 8'h03, 8'hFC}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        chk("R10 reset outputs", {57'b0, seq_busy, stk_we, stk_re, irq_ack, pc_load, flags_load, 1'b0},
            64'd0);
        chk("R10 reset sp", {56'b0, sp_out}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: entry then return round trip, with strobe noise on odd rows (R9).
        for (int i = 0; i < 5; i++) begin
            set_core(VECS[i][31:16], VECS[i][15:8]);
            start_entry(VECS[i][7:0]);
            entry_body(VECS[i][31:16], VECS[i][15:8], VECS[i][7:0], 8'h00, i[0]);
            do_return(VECS[i][31:16], VECS[i][15:8], 8'h03, 1'b0);
        end

        // R2: enable flag clear blocks entry.
        set_core(16'h4321, 8'hFE);
        start_entry(8'h44);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk("R2 no entry with enable clear", {56'b0, seq_busy, stk_we, sp_out[5:0]}, 64'd0);
        end

        // R1: no entry without an instruction boundary.
        insn_done = 1'b0;
        set_core(16'h4321, 8'h01);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk("R1 no entry without boundary", {63'b0, seq_busy}, 64'd0);
        end
        start_entry(8'h44);
        entry_body(16'h4321, 8'h01, 8'h44, 8'h00, 1'b0);

        // R8: nested entry, then chained entry after its return.
        set_core(16'h0A0B, 8'h09);
        start_entry(8'h30);
        entry_body(16'h0A0B, 8'h09, 8'h30, 8'h03, 1'b0);
        irq_active = 1'b1; irq_vector = 8'h38;
        do_return(16'h0A0B, 8'h09, 8'h06, 1'b1);
        entry_body(16'h0A0B, 8'h09, 8'h38, 8'h03, 1'b0);
        chk("R8 chained sp", {56'b0, sp_out}, 64'd6);

        // R10: reset in the middle of an entry.
        set_core(16'h5555, 8'h01);
        start_entry(8'h50);
        @(negedge clk);
        insn_done = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        irq_active = 1'b0;
        @(negedge clk);
        #1;
        chk("R10 mid-sequence reset", {55'b0, seq_busy, stk_we, stk_re, irq_ack, pc_load, flags_load, 3'b0},
            64'd0);
        chk("R10 sp after reset", {56'b0, sp_out}, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule